// File: doc/BRIEF.md
# Keyboard Matrix Scan Controller

This block scans a key matrix of up to 16 rows and 8 columns. It drives one row line at a time, waits out a row dwell, and samples the column lines. Every pressed key found in a scan frame becomes a 7-bit entry holding its row and column, and the entry goes into an 8-deep key queue. A scan tick is derived from the core clock by a divider (`DIV` core cycles per tick), which stands in for the slow 32 kHz scan clock.

The controller starts in idle interrupt mode and scans frames that push nothing until a key shows up. The frame that finds keys pushes them. The controller then waits an initial delay and enters continuous repeat mode. In that mode every frame pushes all held keys, and frames are separated by a repeat delay. The first frame that finds no key returns it to idle. Software sets up and reads the block through a simple register port. The port has a control word, a status word that carries the queue count and two sticky flags, two delay registers, two entry windows that pop on read, and one wake mask per row.

FSM states: `S_OFF` (disabled), `S_START` (5-tick lead-in), `S_ROW` (row dwell), `S_INIT` (initial delay), `S_RPT` (repeat delay). The transitions are:
- Enable: `S_OFF`→`S_START`.
- Lead-in done: `S_START`→`S_ROW`.
- Next row: `S_ROW`→`S_ROW`.
- Frame end: `S_ROW`→`S_INIT` (keys seen, idle mode), `S_ROW`→`S_RPT` (keys seen, continuous mode) or `S_ROW`→`S_START` (no key).
- Delay done: `S_INIT`→`S_START` and `S_RPT`→`S_START`.
- Disable: any state→`S_OFF`.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset, `row_o`, `irq_o` and `wake_o` are 0. The control word (0x00) and status word (0x04) read 0. Every row wake mask reads 0xFF.
- R2: At most one row line is high at a time, and rows are driven in ascending order from 0. Each row is held for (16 + debounce)·DIV core cycles, where debounce is control bits 13:4. With no keys pressed, row 0 rises every (5 + ROWS·(16 + debounce))·DIV cycles.
- R3: An entry byte is {bit 7 valid = 1, bits 6:3 row, bits 2:0 column}. Within a frame, entries are pushed in ascending row order and, within a row, in ascending column order.
- R4: A read of 0x30 or 0x34 returns the oldest four queued entries, with the oldest in bits 7:0. Bytes beyond the queue count read 0. The read removes the entries it returned.
- R5: Status bits 7:4 give the number of queued entries.
- R6: The queue holds 8 entries. A key found while the queue is full is dropped, and the count stays at 8.
- R7: Status bit 2 is set once the count is at least the threshold in control bits 17:14 (a threshold of 0 never sets it). Writing 1 to bit 2 clears it once the count is below the threshold. `irq_o` equals bit 2 AND control bit 3.
- R8: After the frame that first finds keys, the block waits the initial delay (register 0x28, 20 bits, in ticks) before scanning again. Until then it pushes no further entries. After that, each frame repeats the held keys, and frames are separated by the repeat delay (register 0x2C).
- R9: A frame in repeat mode that finds no key returns the block to idle. Idle frames with no key push nothing.
- R10: Row r has a wake mask at 0x38 + 4·r, one bit per column. A key found at a column whose mask bit is 0 sets status bit 0 and `wake_o`. Keys at masked columns (bit 1) leave them unchanged. Writing 1 to status bit 0 clears the flag.
- R11: Clearing control bit 0 stops scanning, and `row_o` is 0 from the next cycle. Queued entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| col_i | input | COLS | Column sense lines, 1 = key closed on the driven row |
| row_o | output | ROWS | Row drive lines, one-hot or zero |
| irq_o | output | 1 | Threshold interrupt |
| wake_o | output | 1 | Wake flag |

## Verification
A scan state machine stuck in a wrong state, or a row index that skips, appears on `row_o` within one row dwell, as a dwell length or row order that does not match the debounce setting. A corrupted queue pointer or count appears at the next status or entry read, as a wrong count or misordered entry bytes. A mode flag that fails to leave repeat mode appears one frame after release, as a count that keeps rising. A missed threshold or wake update appears at `irq_o` or `wake_o` one cycle after the frame row that should have triggered it.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_START,
        S_ROW,
        S_INIT,
        S_RPT
    } scan_state_t;

    localparam int START_TICKS    = 5;
    localparam int ROW_BASE_TICKS = 16;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_STAT   = 8'h04;
    localparam logic [7:0] A_INIT   = 8'h28;
    localparam logic [7:0] A_RPT    = 8'h2C;
    localparam logic [7:0] A_ENT0   = 8'h30;
    localparam logic [7:0] A_ENT1   = 8'h34;
    localparam int         MASK_BASE = 8'h38;

endpackage

// File: rtl/kbd_scan_fsm.sv
module kbd_scan_fsm
    import kbd_scan_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    parameter int DIV  = 1000,
    parameter int DEBW = 10,
    parameter int DLYW = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable_i,
    input  logic [DEBW-1:0]         debounce_i,
    input  logic [DLYW-1:0]         init_dly_i,
    input  logic [DLYW-1:0]         rpt_dly_i,
    input  logic [COLS-1:0]         col_i,
    output logic [ROWS-1:0]         row_o,
    output logic                    hit_o,
    output logic [$clog2(ROWS)-1:0] hit_row_o,
    output logic [COLS-1:0]         hit_cols_o
);
    localparam int RW = $clog2(ROWS);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DLYW-1:0] START_LAST = DLYW'(START_TICKS - 1);
    localparam logic [DLYW-1:0] BASE_LAST  = DLYW'(ROW_BASE_TICKS - 1);

    scan_state_t     state_q, state_n;
    logic [RW-1:0]   row_q, row_n;
    logic [PW-1:0]   pre_q;
    logic [DLYW-1:0] tcnt_q, row_last;
    logic [COLS-1:0] early_q, final_cols;
    logic            cont_q, frame_any_q;
    logic            tick, adv, row_end, last_row, any_key;

    assign tick       = (pre_q == PW'(DIV - 1));
    assign row_last   = BASE_LAST + DLYW'(debounce_i);
    assign last_row   = (row_q == RW'(ROWS - 1));
    assign final_cols = col_i & ((debounce_i == '0) ? col_i : early_q);
    assign any_key    = frame_any_q | (|final_cols);

    // next-state logic
    always_comb begin
        state_n = state_q;
        row_n   = row_q;
        adv     = 1'b0;
        row_end = 1'b0;
        unique case (state_q)
            S_OFF: begin
                state_n = S_START;
                adv     = 1'b1;
            end
            S_START: if (tick && tcnt_q == START_LAST) begin
                state_n = S_ROW;
                row_n   = '0;
                adv     = 1'b1;
            end
            S_ROW: if (tick && tcnt_q == row_last) begin
                row_end = 1'b1;
                adv     = 1'b1;
                if (!last_row) begin
                    row_n = row_q + RW'(1);
                end else if (any_key) begin
                    state_n = cont_q ? S_RPT : S_INIT;
                end else begin
                    state_n = S_START;
                end
            end
            S_INIT: if (init_dly_i == '0 || (tick && (tcnt_q + DLYW'(1)) >= init_dly_i)) begin
                state_n = S_START;
                adv     = 1'b1;
            end
            S_RPT: if (rpt_dly_i == '0 || (tick && (tcnt_q + DLYW'(1)) >= rpt_dly_i)) begin
                state_n = S_START;
                adv     = 1'b1;
            end
            default: state_n = S_OFF;
        endcase
        if (!enable_i) begin
            state_n = S_OFF;
            row_n   = '0;
            row_end = 1'b0;
            adv     = (state_q != S_OFF);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_OFF;
            row_q       <= '0;
            pre_q       <= '0;
            tcnt_q      <= '0;
            early_q     <= '0;
            cont_q      <= 1'b0;
            frame_any_q <= 1'b0;
        end else begin
            state_q <= state_n;
            row_q   <= row_n;
            if (adv) begin
                pre_q  <= '0;
                tcnt_q <= '0;
            end else if (tick) begin
                pre_q  <= '0;
                tcnt_q <= tcnt_q + DLYW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
            if (state_q == S_ROW && tick && tcnt_q == BASE_LAST)
                early_q <= col_i;
            if (state_n == S_OFF) begin
                cont_q      <= 1'b0;
                frame_any_q <= 1'b0;
            end else if (row_end) begin
                if (last_row) begin
                    cont_q      <= any_key;
                    frame_any_q <= 1'b0;
                end else begin
                    frame_any_q <= any_key;
                end
            end
        end
    end

    // outputs
    always_comb begin
        row_o = '0;
        if (state_q == S_ROW) row_o[row_q] = 1'b1;
        hit_o      = row_end;
        hit_row_o  = row_q;
        hit_cols_o = final_cols;
    end

    // R2: never two rows at once
    a_r2_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_o));
    // R2: the driven row holds between ticks
    a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ROW && !tick && enable_i) |=> $stable(row_o));
    // R2: rows advance one step upward
    a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_end && !last_row) |=> (row_o == ($past(row_o) << 1)));

endmodule

// File: rtl/kbd_key_fifo.sv
module kbd_key_fifo #(
    parameter int DEPTH  = 8,
    parameter int W      = 7,
    parameter int POPMAX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [W-1:0]                  data_i,
    input  logic                          pop_i,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic [POPMAX-1:0][W-1:0]      peek_o
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int AW   = $clog2(DEPTH);

    logic [W-1:0]    mem_q [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] count_q, npop;
    logic            push_ok;

    assign push_ok = push_i && (count_q != CNTW'(DEPTH));
    assign npop    = !pop_i ? '0 :
                     (count_q < CNTW'(POPMAX)) ? count_q : CNTW'(POPMAX);

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + AW'(1);
            rd_q    <= rd_q + AW'(npop);
            count_q <= count_q + CNTW'(push_ok) - npop;
        end
    end

    always_comb begin
        for (int k = 0; k < POPMAX; k++) peek_o[k] = mem_q[rd_q + AW'(k)];
    end
    assign count_o = count_q;

    // R6: count never passes the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNTW'(DEPTH));
    // R6: a full queue stays full while not read
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNTW'(DEPTH) && !pop_i) |=> count_q == CNTW'(DEPTH));

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
    import kbd_scan_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 8,
    parameter int DIV   = 1000,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [7:0]      reg_addr_i,
    input  logic [31:0]     reg_wdata_i,
    output logic [31:0]     reg_rdata_o,
    input  logic [COLS-1:0] col_i,
    output logic [ROWS-1:0] row_o,
    output logic            irq_o,
    output logic            wake_o
);
    localparam int RW     = $clog2(ROWS);
    localparam int CW     = $clog2(COLS);
    localparam int CNTW   = $clog2(DEPTH + 1);
    localparam int POPMAX = 4;
    localparam int MASK_END = MASK_BASE + 4 * ROWS;

    logic              en_q, ie_q, thr_flag_q, wake_q;
    logic [9:0]        deb_q;
    logic [3:0]        thr_q;
    logic [19:0]       init_q, rpt_q;
    logic [ROWS-1:0][COLS-1:0] mask_q;
    logic [COLS-1:0]   pend_q, hit_cols;
    logic [RW-1:0]     pend_row_q, hit_row, mask_idx;
    logic [CW-1:0]     col_sel;
    logic              hit, pop, mask_sel, wr_stat;
    logic [CNTW-1:0]   fifo_cnt;
    logic [POPMAX-1:0][6:0] peek;
    logic [31:0]       ent_word;
    logic [7:0]        moff;

    kbd_scan_fsm #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .DEBW(10), .DLYW(20)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable_i(en_q), .debounce_i(deb_q),
        .init_dly_i(init_q), .rpt_dly_i(rpt_q), .col_i(col_i), .row_o(row_o),
        .hit_o(hit), .hit_row_o(hit_row), .hit_cols_o(hit_cols)
    );

    always_comb begin
        col_sel = '0;
        for (int c = COLS - 1; c >= 0; c--) if (pend_q[c]) col_sel = CW'(c);
    end

    kbd_key_fifo #(.DEPTH(DEPTH), .W(7), .POPMAX(POPMAX)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(|pend_q),
        .data_i({4'(pend_row_q), 3'(col_sel)}), .pop_i(pop),
        .count_o(fifo_cnt), .peek_o(peek)
    );

    assign pop      = reg_rd_i && (reg_addr_i == A_ENT0 || reg_addr_i == A_ENT1);
    assign wr_stat  = reg_wr_i && (reg_addr_i == A_STAT);
    assign moff     = reg_addr_i - 8'(MASK_BASE);
    assign mask_idx = moff[RW+1:2];
    assign mask_sel = (9'(reg_addr_i) >= 9'(MASK_BASE)) && (9'(reg_addr_i) < 9'(MASK_END));

    always_comb begin
        for (int k = 0; k < POPMAX; k++)
            ent_word[8*k +: 8] = (CNTW'(k) < fifo_cnt) ? {1'b1, peek[k]} : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; ie_q <= 1'b0; deb_q <= '0; thr_q <= '0;
            init_q <= '0; rpt_q <= '0;
            pend_q <= '0; pend_row_q <= '0;
            thr_flag_q <= 1'b0; wake_q <= 1'b0;
            reg_rdata_o <= '0;
        end else begin
            if (reg_wr_i && reg_addr_i == A_CTRL) begin
                en_q  <= reg_wdata_i[0];
                ie_q  <= reg_wdata_i[3];
                deb_q <= reg_wdata_i[13:4];
                thr_q <= reg_wdata_i[17:14];
            end
            if (reg_wr_i && reg_addr_i == A_INIT) init_q <= reg_wdata_i[19:0];
            if (reg_wr_i && reg_addr_i == A_RPT)  rpt_q  <= reg_wdata_i[19:0];
            if (hit) begin
                pend_q     <= hit_cols;
                pend_row_q <= hit_row;
            end else if (|pend_q) begin
                pend_q[col_sel] <= 1'b0;
            end
            if (thr_q != '0 && 4'(fifo_cnt) >= thr_q) thr_flag_q <= 1'b1;
            else if (wr_stat && reg_wdata_i[2])        thr_flag_q <= 1'b0;
            if (hit && |(hit_cols & ~mask_q[hit_row])) wake_q <= 1'b1;
            else if (wr_stat && reg_wdata_i[0])        wake_q <= 1'b0;
            if (reg_rd_i) begin
                if (mask_sel)
                    reg_rdata_o <= 32'(mask_q[mask_idx]);
                else begin
                    unique case (reg_addr_i)
                        A_CTRL:         reg_rdata_o <= {14'b0, thr_q, deb_q, ie_q, 2'b0, en_q};
                        A_STAT:         reg_rdata_o <= {24'b0, 4'(fifo_cnt), 1'b0, thr_flag_q, 1'b0, wake_q};
                        A_INIT:         reg_rdata_o <= {12'b0, init_q};
                        A_RPT:          reg_rdata_o <= {12'b0, rpt_q};
                        A_ENT0, A_ENT1: reg_rdata_o <= ent_word;
                        default:        reg_rdata_o <= '0;
                    endcase
                end
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[r] <= '1;
            else if (reg_wr_i && mask_sel && mask_idx == RW'(r))
                mask_q[r] <= reg_wdata_i[COLS-1:0];
        end
    end

    assign irq_o  = thr_flag_q & ie_q;
    assign wake_o = wake_q;

    // R7: flag rises only after the count reached a nonzero threshold
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_flag_q) |-> ($past(thr_q) != '0 && 4'($past(fifo_cnt)) >= $past(thr_q)));
    // R10: wake rises only on a scanned row result
    a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(hit));
    // R11: disabled controller releases the rows
    a_r11_rows_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> row_o == '0);

endmodule

// File: tb/kbd_matrix_scan_bench.sv
module kbd_matrix_scan_bench;
    localparam int ROWS = 16;
    localparam int COLS = 8;
    localparam int DIV  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0, reg_rdata;
    logic [COLS-1:0] col;
    logic [ROWS-1:0] row;
    logic            irq, wake;
    logic [ROWS-1:0][COLS-1:0] keys = '0;
    int              n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    kbd_matrix_scan #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .DEPTH(8)) u_kbd_matrix_scan (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .col_i(col), .row_o(row), .irq_o(irq), .wake_o(wake)
    );

    always_comb begin
        col = '0;
        for (int r = 0; r < ROWS; r++) if (row[r]) col = col | keys[r];
    end

    function automatic int frame_clks(input int deb);
        return (5 + ROWS * (16 + deb)) * DIV;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_count(input int n, input int limit);
        logic [31:0] s;
        for (int t = 0; t < limit; t += 20) begin
            rd(8'h04, s);
            if (s[7:4] == 4'(n)) break;
            idle(18);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 row_o", 32'(row), 0);
        check("R1 irq_o", 32'(irq), 0);
        check("R1 wake_o", 32'(wake), 0);
        rd(8'h00, d); check("R1 ctrl", d, 0);
        rd(8'h04, d); check("R1 status", d, 0);
        rd(8'h38, d); check("R1 mask row0", d, 32'hFF);
        rd(8'h74, d); check("R1 mask row15", d, 32'hFF);
    endtask

    task automatic t_timing();
        int p, hi;
        wr(8'h00, 32'h31);            // enable, debounce 3
        for (int t = 0; t < 2000 && row != 16'h1; t++) @(negedge clk);
        p = 0;
        while (row == 16'h1 && p < 5000) begin @(negedge clk); p++; end
        hi = p;
        check("R2 row dwell", hi, (16 + 3) * DIV);
        check("R2 next row", 32'(row), 32'h2);
        while (row != 16'h1 && p < 5000) begin @(negedge clk); p++; end
        check("R2 frame period", p, frame_clks(3));
        wr(8'h00, 32'h0);
        idle(2);
        check("R11 rows released", 32'(row), 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        keys[5][2] = 1'b1;
        wr(8'h28, 1000); wr(8'h2C, 10);
        wr(8'h00, 32'h1 | 32'h8 | (32'd1 << 14));
        for (int t = 0; t < 3 * frame_clks(0) && !irq; t++) @(negedge clk);
        check("R7 irq at threshold", 32'(irq), 1);
        rd(8'h04, d); check("R5 R7 status one entry", d, 32'h14);
        idle(2 * frame_clks(0));
        rd(8'h04, d); check("R8 no repeat in initial delay", d[7:4], 1);
        wr(8'h00, 32'h0);
        rd(8'h30, d); check("R3 R4 single entry", d, 32'h0000_00AA);
        rd(8'h04, d); check("R11 R4 popped", d, 32'h04);
        wr(8'h04, 32'h4);
        rd(8'h04, d); check("R7 flag cleared", d, 0);
        check("R7 irq low", 32'(irq), 0);
        keys = '0;
    endtask

    task automatic t_multi();
        logic [31:0] d;
        keys[3][1] = 1'b1; keys[3][6] = 1'b1; keys[10][0] = 1'b1;
        wr(8'h00, 32'h1 | (32'd4 << 14));   // threshold 4, irq disabled
        idle(2 * frame_clks(0));
        rd(8'h04, d); check("R5 R7 three entries below threshold", d, 32'h30);
        wr(8'h00, 32'h1 | (32'd3 << 14));
        idle(3);
        rd(8'h04, d); check("R7 flag at equal count", d, 32'h34);
        check("R7 irq gated by enable bit", 32'(irq), 0);
        wr(8'h00, 32'h0);
        rd(8'h34, d); check("R3 R4 ordered entries", d, 32'h00D0_9E99);
        wr(8'h04, 32'h4);
        keys = '0;
    endtask

    task automatic t_repeat();
        logic [31:0] d;
        keys[5][2] = 1'b1;
        wr(8'h28, 10); wr(8'h2C, 10);
        wr(8'h00, 32'h1);
        wait_count(8, 14 * frame_clks(0));
        rd(8'h04, d); check("R8 repeats fill queue", d[7:4], 8);
        idle(2 * frame_clks(0));
        rd(8'h04, d); check("R6 count saturates", d[7:4], 8);
        keys = '0;
        idle(3 * frame_clks(0));
        rd(8'h30, d); check("R4 R6 first four", d, 32'hAAAA_AAAA);
        rd(8'h34, d); check("R4 R6 last four", d, 32'hAAAA_AAAA);
        rd(8'h30, d); check("R4 empty read", d, 0);
        idle(3 * frame_clks(0));
        rd(8'h04, d); check("R9 idle pushes nothing", d[7:4], 0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(8'h4C, 32'hFB);
        rd(8'h4C, d); check("R10 mask readback", d, 32'hFB);
        wr(8'h28, 1000);
        keys[5][3] = 1'b1;
        wr(8'h00, 32'h1);
        idle(2 * frame_clks(0));
        check("R10 masked key no wake", 32'(wake), 0);
        wr(8'h00, 32'h0);
        rd(8'h30, d);
        keys = '0; keys[5][2] = 1'b1;
        wr(8'h00, 32'h1);
        idle(2 * frame_clks(0));
        check("R10 unmasked key wakes", 32'(wake), 1);
        wr(8'h00, 32'h0);
        keys = '0;
        rd(8'h04, d); check("R10 status bit0", d[0], 1);
        wr(8'h04, 32'h1);
        idle(1);
        check("R10 wake cleared", 32'(wake), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_timing();
        t_single();
        t_multi();
        t_repeat();
        t_wake();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule